// File: doc/BRIEF.md
# Charger Start-up Supervisory Sequencer

This block is the synchronous controller on the secondary side of a fast-charge power adapter. Its inputs are comparator flags that have already been digitised: the supply is above the undervoltage lockout (UVLO) level, the supply is above 1.05 times the default output, the output is stable, and each of the two CC lines is below the attach threshold. It also takes a completion flag from the loader that fetches the safe defaults (5 V, 3 A) from non-volatile storage. Its outputs are the enable for the external load switch, the enable for the overshoot discharge sink, a one-cycle initialise strobe, a low-power flag and a protocol-enable flag.

After the supply rises above UVLO, the sequencer strobes initialisation and waits for the defaults to load. It then lets the output settle at the default regulation point. It closes the load switch only after the output has been stable for a debounce period. At that point it idles in a low-power state until an attach appears on either CC line, and then it enables all circuits. A request to change voltage or current is granted only while the block is active and a protocol has been detected.

If the supply collapses while the switch is closed, the block treats it as an output short. The switch opens in the same cycle. A restart timer then requires the supply to stay above UVLO without a break for a set number of clocks before initialisation runs again.

Top module: `chg_startup_seq`

## Requirements
- R1: In reset, `state_o` is 0 (no supply) and every other output is low. The state codes are 0 no-supply, 1 init, 2 default regulation, 3 wait-for-attach, 4 active, 5 fault-restart.
- R2: When `supply_ok` is high at a clock edge in state 0, the next state is 1. `init_pulse` is high only during the first cycle in state 1. State 1 moves to state 2 on the first edge with `dflt_done` high.
- R3: `load_sw_en` is high only in states 3 and 4, and only while `supply_ok` is high. It drops in the same cycle that `supply_ok` falls.
- R4: After each edge, `sink_en` equals the value of `vcc_over AND supply_ok` sampled at that edge. There is no hysteresis.
- R5: State 2 moves to state 3 on the DEB_CYC-th consecutive edge with `out_stable` high. Any low sample restarts the count.
- R6: In state 3, `low_pwr` is high and `proto_en` is low.
- R7: In state 3, an edge with `cc1_low` or `cc2_low` high moves the block to state 4. In state 4, `proto_en` is high and `low_pwr` is low.
- R8: `req_accept` equals `chg_req AND proto_det` while in state 4, and is 0 in every other state. It is combinational.
- R9: If `supply_ok` is low at an edge in state 3 or 4, the next state is 5.
- R10: State 5 moves to state 1 on the RESTART_CYC-th consecutive edge with `supply_ok` high, and `init_pulse` fires. Any low sample restarts the count.
- R11: If `supply_ok` is low at an edge in state 1 or 2, the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply above UVLO |
| vcc_over | input | 1 | Supply above 1.05x default output |
| out_stable | input | 1 | Output-stable comparator flag |
| cc1_low | input | 1 | CC line 1 below attach threshold |
| cc2_low | input | 1 | CC line 2 below attach threshold |
| dflt_done | input | 1 | Defaults loader finished |
| proto_det | input | 1 | A charging protocol has been detected |
| chg_req | input | 1 | Voltage/current change request |
| load_sw_en | output | 1 | Load switch enable |
| sink_en | output | 1 | Overshoot discharge sink enable |
| init_pulse | output | 1 | One-cycle initialise/load-defaults strobe |
| low_pwr | output | 1 | Low-power wait-for-attach flag |
| proto_en | output | 1 | Protocol circuitry enable |
| req_accept | output | 1 | Change request granted |
| state_o | output | 3 | Current sequencer state code |

## Verification
`load_sw_en` and `req_accept` are combinational, so the bench checks them a short delay after it changes an input, before the next clock edge. `state_o`, `init_pulse` and `sink_en` update on the first edge after the stimulus. The debounce exit comes on the DEB_CYC-th qualifying edge, and the restart exit on the RESTART_CYC-th. The bench drives every input on the falling edge and samples on a later falling edge, counting edges exactly. For the two timers it also checks one edge before the exit. It sweeps every glitch position inside the debounce window and one glitch inside the restart window, so that a wrong count shows up as a state mismatch.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_INIT  = 3'd1,
    ST_DFLT  = 3'd2,
    ST_IDLE  = 3'd3,
    ST_RUN   = 3'd4,
    ST_RETRY = 3'd5
  } seq_state_e;

  // Load switch may conduct only in these states
  function automatic logic switch_closed(seq_state_e s);
    return (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  // Grant of a voltage/current change request
  function automatic logic req_grant(seq_state_e s, logic det, logic req);
    return (s == ST_RUN) && det && req;
  endfunction

endpackage

// File: rtl/chg_run_timer.sv
// Counts consecutive edges with en && level; done on the LIMIT-th one.
module chg_run_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          qualify;

  assign qualify = en && level;
  assign done    = qualify && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !qualify || done) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chg_sink_ctrl.sv
// Hysteresis-free overshoot sink: follows the comparator, one register stage.
module chg_sink_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic vcc_over,
  output logic sink_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) sink_en <= 1'b0;
    else        sink_en <= supply_ok && vcc_over;
  end
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       dflt_done,
  input  logic       stable_done,
  input  logic       attach,
  input  logic       restart_done,
  output seq_state_e state,
  output logic       init_pulse
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (supply_ok) nxt = ST_INIT;
      ST_INIT:  if (!supply_ok) nxt = ST_OFF;   else if (dflt_done)   nxt = ST_DFLT;
      ST_DFLT:  if (!supply_ok) nxt = ST_OFF;   else if (stable_done) nxt = ST_IDLE;
      ST_IDLE:  if (!supply_ok) nxt = ST_RETRY; else if (attach)      nxt = ST_RUN;
      ST_RUN:   if (!supply_ok) nxt = ST_RETRY;
      ST_RETRY: if (restart_done) nxt = ST_INIT;
      default:  nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      init_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      init_pulse <= (nxt == ST_INIT) && (state != ST_INIT);
    end
  end
endmodule

// File: rtl/chg_startup_seq.sv
module chg_startup_seq
  import chg_seq_pkg::*;
#(
  parameter int DEB_CYC     = 256,
  parameter int RESTART_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       vcc_over,
  input  logic       out_stable,
  input  logic       cc1_low,
  input  logic       cc2_low,
  input  logic       dflt_done,
  input  logic       proto_det,
  input  logic       chg_req,
  output logic       load_sw_en,
  output logic       sink_en,
  output logic       init_pulse,
  output logic       low_pwr,
  output logic       proto_en,
  output logic       req_accept,
  output logic [2:0] state_o
);
  seq_state_e state;
  logic       stable_done;
  logic       restart_done;
  logic       attach;
  logic       in_dflt;
  logic       in_retry;

  assign attach   = cc1_low || cc2_low;
  assign in_dflt  = (state == ST_DFLT);
  assign in_retry = (state == ST_RETRY);

  chg_run_timer #(.LIMIT(DEB_CYC)) stable_tmr_i (
    .clk(clk), .rst_n(rst_n), .en(in_dflt), .level(out_stable), .done(stable_done)
  );

  chg_run_timer #(.LIMIT(RESTART_CYC)) restart_tmr_i (
    .clk(clk), .rst_n(rst_n), .en(in_retry), .level(supply_ok), .done(restart_done)
  );

  chg_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dflt_done(dflt_done),
    .stable_done(stable_done), .attach(attach), .restart_done(restart_done),
    .state(state), .init_pulse(init_pulse)
  );

  chg_sink_ctrl sink_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vcc_over(vcc_over), .sink_en(sink_en)
  );

  // Switch opens combinationally the moment the supply collapses
  assign load_sw_en = switch_closed(state) && supply_ok;
  assign low_pwr    = (state == ST_IDLE);
  assign proto_en   = (state == ST_RUN);
  assign req_accept = req_grant(state, proto_det, chg_req);
  assign state_o    = state;
endmodule

// File: rtl/chg_startup_seq_chk.sv
module chg_startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       vcc_over,
  input logic       proto_det,
  input logic       chg_req,
  input logic       load_sw_en,
  input logic       sink_en,
  input logic       init_pulse,
  input logic       low_pwr,
  input logic       req_accept,
  input logic [2:0] state_o
);
  p_sw_open_uvlo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !load_sw_en);

  p_init_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);

  p_sink_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sink_en == ($past(vcc_over) && $past(supply_ok))));

  p_lowpwr_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(low_pwr) && $past(rst_n)) |-> ($past(state_o) == 3'd2));

  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (proto_det && chg_req && state_o == 3'd4));

  p_short_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd3 || state_o == 3'd4) && !supply_ok) |=> (state_o == 3'd5));

  p_uvlo_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd1 || state_o == 3'd2) && !supply_ok) |=> (state_o == 3'd0));
endmodule

bind chg_startup_seq chg_startup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vcc_over(vcc_over),
  .proto_det(proto_det), .chg_req(chg_req), .load_sw_en(load_sw_en),
  .sink_en(sink_en), .init_pulse(init_pulse), .low_pwr(low_pwr),
  .req_accept(req_accept), .state_o(state_o)
);

// File: tb/chg_startup_seq_tb_top.sv
`timescale 1ns/1ps
module chg_startup_seq_tb_top;
  localparam int DEB = 4;
  localparam int RST = 6;

  logic clk = 1'b0;
  logic rst_n, supply_ok, vcc_over, out_stable, cc1_low, cc2_low;
  logic dflt_done, proto_det, chg_req;
  logic load_sw_en, sink_en, init_pulse, low_pwr, proto_en, req_accept;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  chg_startup_seq #(.DEB_CYC(DEB), .RESTART_CYC(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vcc_over(vcc_over),
    .out_stable(out_stable), .cc1_low(cc1_low), .cc2_low(cc2_low),
    .dflt_done(dflt_done), .proto_det(proto_det), .chg_req(chg_req),
    .load_sw_en(load_sw_en), .sink_en(sink_en), .init_pulse(init_pulse),
    .low_pwr(low_pwr), .proto_en(proto_en), .req_accept(req_accept),
    .state_o(state_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic up_to_idle();
    supply_ok = 1'b1; tick(1);
    check("R2 init entry", state_o, 1);
    dflt_done = 1'b1; tick(1); dflt_done = 1'b0;
    check("R2 to default regulation", state_o, 2);
    out_stable = 1'b1; tick(DEB);
    check("R5 debounced exit", state_o, 3);
  endtask

  initial begin
    rst_n = 0; supply_ok = 0; vcc_over = 0; out_stable = 0; cc1_low = 0;
    cc2_low = 0; dflt_done = 0; proto_det = 0; chg_req = 0;
    tick(2);
    check("R1 state", state_o, 0);
    check("R1 outs", {load_sw_en, sink_en, init_pulse, low_pwr, proto_en, req_accept}, 0);
    rst_n = 1'b1; tick(1);
    check("R1 idle without supply", state_o, 0);

    supply_ok = 1'b1; tick(1);
    check("R2 state init", state_o, 1);
    check("R2 pulse high", init_pulse, 1);
    tick(1);
    check("R2 pulse single", init_pulse, 0);
    check("R2 wait loader", state_o, 1);

    for (int i = 0; i < 4; i++) begin
      vcc_over = i[0]; tick(1);
      check("R4 sink follows", sink_en, {31'd0, i[0]});
    end
    vcc_over = 1'b0;

    dflt_done = 1'b1; tick(1); dflt_done = 1'b0;
    check("R2 default regulation", state_o, 2);
    check("R3 switch open", load_sw_en, 0);

    for (int g = 1; g < DEB; g++) begin
      out_stable = 1'b1; tick(g);
      check("R5 still settling", state_o, 2);
      out_stable = 1'b0; tick(1);
      check("R5 glitch restarts", state_o, 2);
    end
    out_stable = 1'b1; tick(DEB - 1);
    check("R5 one short", state_o, 2);
    tick(1);
    check("R5 exit", state_o, 3);
    check("R3 switch closed", load_sw_en, 1);
    check("R6 low power", low_pwr, 1);
    check("R6 protocol off", proto_en, 0);
    chg_req = 1'b1; proto_det = 1'b1; #1;
    check("R8 no grant before attach", req_accept, 0);
    chg_req = 1'b0; proto_det = 1'b0;

    cc2_low = 1'b1; tick(1); cc2_low = 1'b0;
    check("R7 attach cc2", state_o, 4);
    check("R7 protocol on", proto_en, 1);
    check("R7 low power off", low_pwr, 0);
    chg_req = 1'b1; #1;
    check("R8 no protocol", req_accept, 0);
    proto_det = 1'b1; #1;
    check("R8 granted", req_accept, 1);
    chg_req = 1'b0; #1;
    check("R8 no request", req_accept, 0);

    supply_ok = 1'b0; #1;
    check("R3 opens at once", load_sw_en, 0);
    vcc_over = 1'b1; tick(1);
    check("R9 fault state", state_o, 5);
    tick(1);
    check("R4 sink off below UVLO", sink_en, 0);
    vcc_over = 1'b0;
    supply_ok = 1'b1; tick(RST - 1);
    check("R10 still waiting", state_o, 5);
    supply_ok = 1'b0; tick(1);
    check("R10 glitch holds", state_o, 5);
    supply_ok = 1'b1; tick(RST - 1);
    check("R10 one short", state_o, 5);
    tick(1);
    check("R10 restart init", state_o, 1);
    check("R10 init pulse", init_pulse, 1);

    supply_ok = 1'b0; tick(1);
    check("R11 init to off", state_o, 0);
    supply_ok = 1'b1; tick(1);
    dflt_done = 1'b1; tick(1); dflt_done = 1'b0;
    supply_ok = 1'b0; tick(1);
    check("R11 default to off", state_o, 0);
    out_stable = 1'b0;
    up_to_idle();
    cc1_low = 1'b1; tick(1); cc1_low = 1'b0;
    check("R7 attach cc1", state_o, 4);
    supply_ok = 1'b0; tick(1);
    check("R9 fault again", state_o, 5);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule